// File: doc/BRIEF.md
# I2C Slave Receiver with Clock Stretching

This block listens on an open-drain two-wire bus as a slave that only receives. It watches for bus start and stop conditions and takes the first frame after each start as a 7-bit address followed by a read/write bit. It compares the address with an own-address input. When the address matches, the block drives the acknowledge slot and takes every later byte of the transfer. A host on the system clock reads each received byte from a data register. A full flag tells the host that a byte is waiting.

The host clears the full flag with a read strobe. The address frame also sets the flag, so the host must make one dummy read of the address byte. Suppose a byte is still unread when the 8th SCL clock of the next frame falls. The block then holds SCL low and stalls the master until the host reads. The new byte stays in the shift register during the stall, so no byte is lost. The host chooses the acknowledge level with a control input. That level is captured at the first clock of each frame, so a change takes effect from the next frame.

Top module: `i2c_rx_slave`

## Requirements
- R1: While `en` is 0, the block drives neither line low, keeps `rx_full` and `addressed` at 0, and ignores all bus traffic. After reset the same outputs are 0.
- R2: A start condition is SDA falling while SCL is high. A stop condition is SDA rising while SCL is high. A stop returns the block to waiting for an address, clears `addressed`, and releases both lines.
- R3: Bits are sampled on SCL rising edges, MSB first. In the first frame after a start, bits 7:1 are the address and bit 0 is the R/W bit. On a match, `sda_oe` is set to the captured acknowledge level from the 8th SCL falling edge to the 9th SCL falling edge. `addressed` goes to 1 at the 9th SCL rising edge.
- R4: On an address mismatch, SDA is left released in the acknowledge slot and `rx_full` is not set. Every byte is ignored until the next start condition.
- R5: At the 9th SCL rising edge of every frame it accepts (the address frame and each later data frame), the block copies the received byte into `rx_data` and sets `rx_full`. After the address frame, `rx_data` = {address, R/W}.
- R6: A one-cycle `rd_stb` pulse clears `rx_full`. The last byte of a transfer is read the same way as every other byte.
- R7: If `rx_full` is still 1 when the 8th SCL clock falls, `scl_oe` holds SCL low until the read clears the flag. The incoming byte is kept, so `rx_data` never changes while `rx_full` is 1 and no byte is lost.
- R8: `ack_lvl` = 0 pulls SDA low in the acknowledge slot (ACK). `ack_lvl` = 1 leaves SDA released (NACK). The value is captured at the first SCL rising edge of each frame, so a change made during a frame applies from the next frame.
- R9: The block starts pulling SDA low only while SCL is low.
- R10: A repeated start, with no stop before it, returns the block to the address phase. The block clears `addressed` and decodes the next frame as an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Interface enable |
| own_addr | input | ADDR_W | Slave address to match |
| ack_lvl | input | 1 | Acknowledge level: 0 = ACK, 1 = NACK |
| rd_stb | input | 1 | Data register read strobe, clears the full flag |
| rx_data | output | DATA_W | Received byte register |
| rx_full | output | 1 | A received byte is waiting |
| addressed | output | 1 | This slave is selected in the current transfer |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (stretch) |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The bound checker checks every cycle that the block starts pulling SDA low only while SCL is low. It also checks that a stretch starts only with a byte unread, that `rx_data` stays frozen while the flag is set, that the flag clears only after a read strobe, that loads happen only when addressed, and that the block stays quiet while disabled. The bench scenarios alone show the byte order and the address decode. They also show the acknowledge level that appears in each slot, the frame at which a changed `ack_lvl` takes effect, the behaviour after a mismatch, and that no byte is lost when the host reads late. Repeated starts and stops are covered by scenarios as well.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_BITS,
      ST_ACK,
      ST_SKIP
   } rx_state_e;

   typedef struct packed {
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
   } bus_evt_t;
endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '1;
      else        stg[0] <= d;
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[g] <= '1;
         else        stg[g] <= stg[g-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_rx_cond.sv
module i2c_rx_cond
   import i2c_rx_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_s,
   input  logic     sda_s,
   output bus_evt_t evt
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_comb begin
      evt.scl_rise = scl_s & ~scl_q;
      evt.scl_fall = ~scl_s & scl_q;
      evt.start    = scl_s & scl_q & sda_q & ~sda_s;
      evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
   end
endmodule

// File: rtl/i2c_rx_dreg.sv
module i2c_rx_dreg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              rd_stb,
   output logic [DATA_W-1:0] data,
   output logic              full
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data <= '0;
         full <= 1'b0;
      end else if (!en) begin
         full <= 1'b0;
      end else if (load) begin
         data <= load_data;
         full <= 1'b1;
      end else if (rd_stb) begin
         full <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine
   import i2c_rx_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  bus_evt_t          evt,
   input  logic              sda_s,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              ack_lvl,
   input  logic              full,
   input  logic              rd_stb,
   output logic              load,
   output logic [DATA_W-1:0] load_data,
   output logic              sda_oe,
   output logic              scl_oe,
   output logic              addressed
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

   rx_state_e         state;
   logic [CNT_W-1:0]  bitcnt;
   logic [DATA_W-1:0] shreg;
   logic              addr_frame;
   logic              ack_q;
   logic              hit;

   assign hit       = (shreg[DATA_W-1 -: ADDR_W] == own_addr);
   assign load      = en && (state == ST_ACK) && evt.scl_rise;
   assign load_data = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         bitcnt     <= '0;
         shreg      <= '0;
         addr_frame <= 1'b0;
         ack_q      <= 1'b0;
         sda_oe     <= 1'b0;
         scl_oe     <= 1'b0;
         addressed  <= 1'b0;
      end else if (!en) begin
         state      <= ST_IDLE;
         bitcnt     <= '0;
         addr_frame <= 1'b0;
         sda_oe     <= 1'b0;
         scl_oe     <= 1'b0;
         addressed  <= 1'b0;
      end else if (evt.start) begin
         state      <= ST_BITS;
         bitcnt     <= '0;
         addr_frame <= 1'b1;
         addressed  <= 1'b0;
         sda_oe     <= 1'b0;
         scl_oe     <= 1'b0;
      end else if (evt.stop) begin
         state      <= ST_IDLE;
         addressed  <= 1'b0;
         sda_oe     <= 1'b0;
         scl_oe     <= 1'b0;
      end else begin
         unique case (state)
            ST_BITS: begin
               if (evt.scl_rise && bitcnt != LAST_BIT) begin
                  shreg  <= {shreg[DATA_W-2:0], sda_s};
                  bitcnt <= bitcnt + 1'b1;
                  if (bitcnt == '0) ack_q <= ack_lvl;
               end
               if (evt.scl_fall && bitcnt == LAST_BIT) begin
                  if (addr_frame && !hit) begin
                     state <= ST_SKIP;
                  end else begin
                     state  <= ST_ACK;
                     sda_oe <= ~ack_q;
                     scl_oe <= full && !rd_stb;
                  end
               end
            end
            ST_ACK: begin
               if (scl_oe && !full)            scl_oe    <= 1'b0;
               if (evt.scl_rise && addr_frame) addressed <= 1'b1;
               if (evt.scl_fall) begin
                  sda_oe     <= 1'b0;
                  state      <= ST_BITS;
                  bitcnt     <= '0;
                  addr_frame <= 1'b0;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/i2c_rx_slave.sv
module i2c_rx_slave
   import i2c_rx_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              ack_lvl,
   input  logic              rd_stb,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              addressed,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe
);
   if (DATA_W != ADDR_W + 1) begin : g_bad_width
      $error("DATA_W must equal ADDR_W + 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [1:0]        line_s;
   bus_evt_t          evt;
   logic              load;
   logic [DATA_W-1:0] load_data;

   i2c_rx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(line_s)
   );

   i2c_rx_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(line_s[1]), .sda_s(line_s[0]), .evt(evt)
   );

   i2c_rx_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .en(en), .evt(evt), .sda_s(line_s[0]),
      .own_addr(own_addr), .ack_lvl(ack_lvl), .full(rx_full), .rd_stb(rd_stb),
      .load(load), .load_data(load_data), .sda_oe(sda_oe), .scl_oe(scl_oe),
      .addressed(addressed)
   );

   i2c_rx_dreg #(.DATA_W(DATA_W)) u_dreg (
      .clk(clk), .rst_n(rst_n), .en(en), .load(load), .load_data(load_data),
      .rd_stb(rd_stb), .data(rx_data), .full(rx_full)
   );
endmodule

// File: rtl/i2c_rx_slave_chk.sv
module i2c_rx_slave_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              rd_stb,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_full,
   input logic              addressed,
   input logic              scl_i,
   input logic              scl_oe,
   input logic              sda_oe
);
   p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!sda_oe && !scl_oe && !rx_full));

   p_load_addressed_r5: assert property (@(posedge clk) disable iff (!rst_n || !en)
      $rose(rx_full) |-> addressed);

   p_clear_by_read_r6: assert property (@(posedge clk) disable iff (!rst_n || !en)
      $fell(rx_full) |-> $past(rd_stb));

   p_stretch_needs_full_r7: assert property (@(posedge clk) disable iff (!rst_n || !en)
      $rose(scl_oe) |-> rx_full);

   p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n || !en)
      (rx_full && $past(rx_full)) |-> $stable(rx_data));

   p_sda_when_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_i);
endmodule

bind i2c_rx_slave i2c_rx_slave_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .rd_stb(rd_stb), .rx_data(rx_data),
   .rx_full(rx_full), .addressed(addressed), .scl_i(scl_i), .scl_oe(scl_oe),
   .sda_oe(sda_oe)
);

// File: tb/i2c_rx_slave_bench.sv
module i2c_rx_slave_bench;
   localparam int HALF = 40;
   localparam logic [6:0] OWN = 7'h5A;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n, en, ack_lvl, rd_stb;
   logic [6:0] own_addr;
   logic [7:0] rx_data;
   logic       rx_full, addressed, scl_oe, sda_oe;
   logic       scl_m = 1'b1, sda_m = 1'b1;
   wire        scl_ln = scl_m & ~scl_oe;
   wire        sda_ln = sda_m & ~sda_oe;

   int n_chk = 0, n_bad = 0, rd_delay = 4, stretch_seen = 0;
   bit done = 0;
   logic [7:0] exp_q[$];

   i2c_rx_slave u_i2c_rx_slave (
      .clk(clk), .rst_n(rst_n), .en(en), .own_addr(own_addr), .ack_lvl(ack_lvl),
      .rd_stb(rd_stb), .rx_data(rx_data), .rx_full(rx_full), .addressed(addressed),
      .scl_i(scl_ln), .sda_i(sda_ln), .scl_oe(scl_oe), .sda_oe(sda_oe)
   );

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(output logic smp);
      wait_clk(HALF);
      scl_m = 1'b1;
      while (scl_ln !== 1'b1) @(negedge clk);
      wait_clk(HALF / 2);
      smp = sda_ln;
      wait_clk(HALF / 2);
      scl_m = 1'b0;
   endtask

   task automatic start_c();
      wait_clk(4);
      sda_m = 1'b1;
      wait_clk(4);
      scl_m = 1'b1;
      while (scl_ln !== 1'b1) @(negedge clk);
      wait_clk(HALF);
      sda_m = 1'b0;
      wait_clk(HALF);
      scl_m = 1'b0;
   endtask

   task automatic stop_c();
      wait_clk(4);
      sda_m = 1'b0;
      wait_clk(HALF);
      scl_m = 1'b1;
      while (scl_ln !== 1'b1) @(negedge clk);
      wait_clk(HALF);
      sda_m = 1'b1;
      wait_clk(HALF);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit load, output logic ackbit, input int flip = -1);
      logic dummy;
      if (load) exp_q.push_back(b);
      for (int i = 7; i >= 0; i--) begin
         wait_clk(4);
         sda_m = b[i];
         pulse(dummy);
         if (flip >= 0 && i == 7) ack_lvl = flip[0];
      end
      wait_clk(4);
      sda_m = 1'b1;
      pulse(ackbit);
   endtask

   // Scoreboard monitor acting as host: reads each byte after rd_delay cycles
   initial begin
      rd_stb = 1'b0;
      forever begin
         @(negedge clk);
         if (rx_full === 1'b1) begin
            wait_clk(rd_delay);
            if (scl_oe === 1'b1) begin
               stretch_seen++;
               chk(scl_ln == 1'b0, "R7", "SCL held low during stretch", scl_ln, 0);
            end
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4", "unexpected byte load", rx_data, 0);
            end else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               chk(rx_data == e, "R5", "received byte", rx_data, e);
            end
            rd_stb = 1'b1;
            @(negedge clk);
            rd_stb = 1'b0;
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic a;
      rst_n = 1'b0; en = 1'b0; ack_lvl = 1'b0; own_addr = OWN;
      wait_clk(10);
      rst_n = 1'b1;
      wait_clk(2);
      chk(sda_oe == 0, "R1", "sda_oe after reset", sda_oe, 0);
      chk(scl_oe == 0, "R1", "scl_oe after reset", scl_oe, 0);
      chk(rx_full == 0, "R1", "rx_full after reset", rx_full, 0);
      chk(addressed == 0, "R1", "addressed after reset", addressed, 0);

      // R1: disabled block ignores a matching address
      start_c();
      send_byte({OWN, 1'b0}, 0, a);
      chk(a == 1'b1, "R1", "no ACK while disabled", a, 1);
      stop_c();
      chk(rx_full == 0, "R1", "no flag while disabled", rx_full, 0);

      en = 1'b1;
      wait_clk(10);

      // R3/R5/R6: plain write transfer, prompt reads
      start_c();
      send_byte({OWN, 1'b0}, 1, a);
      chk(a == 1'b0, "R3", "ACK on address match", a, 0);
      wait_clk(10);
      chk(addressed == 1, "R3", "addressed after match", addressed, 1);
      send_byte(8'hC3, 1, a);
      chk(a == 1'b0, "R8", "ACK data C3", a, 0);
      send_byte(8'h3C, 1, a);
      chk(a == 1'b0, "R8", "ACK data 3C", a, 0);
      send_byte(8'h01, 1, a);
      stop_c();
      chk(addressed == 0, "R2", "addressed cleared by stop", addressed, 0);
      chk(sda_oe == 0 && scl_oe == 0, "R2", "lines released after stop", {sda_oe, scl_oe}, 0);
      wait_clk(50);
      chk(exp_q.size() == 0, "R6", "last byte read normally", exp_q.size(), 0);
      chk(stretch_seen == 0, "R7", "no stretch with prompt reads", stretch_seen, 0);

      // R4: mismatch, following bytes ignored
      start_c();
      send_byte({OWN ^ 7'h01, 1'b0}, 0, a);
      chk(a == 1'b1, "R4", "NACK on mismatch", a, 1);
      send_byte(8'hFF, 0, a);
      chk(a == 1'b1, "R4", "byte after mismatch not acked", a, 1);
      chk(addressed == 0, "R4", "not addressed after mismatch", addressed, 0);
      chk(rx_full == 0, "R4", "no flag after mismatch", rx_full, 0);
      stop_c();

      // R8: ack level latched per frame
      start_c();
      send_byte({OWN, 1'b1}, 1, a);
      chk(a == 1'b0, "R8", "ACK on read address", a, 0);
      send_byte(8'h96, 1, a, 1);
      chk(a == 1'b0, "R8", "mid-frame change keeps old level", a, 0);
      send_byte(8'h69, 1, a);
      chk(a == 1'b1, "R8", "new level NACK next frame", a, 1);
      ack_lvl = 1'b0;
      send_byte(8'hAA, 1, a);
      chk(a == 1'b0, "R8", "level restored between frames", a, 0);
      stop_c();
      wait_clk(50);

      // R7: late host reads force stretching, no byte lost
      rd_delay = 1500;
      start_c();
      send_byte({OWN, 1'b0}, 1, a);
      send_byte(8'h5E, 1, a);
      chk(stretch_seen >= 1, "R7", "stretch on unread byte", stretch_seen, 1);
      chk(a == 1'b0, "R7", "ACK after stretch", a, 0);
      send_byte(8'hE5, 1, a);
      chk(stretch_seen >= 2, "R7", "second stretch", stretch_seen, 2);
      rd_delay = 4;
      send_byte(8'h42, 1, a);
      stop_c();
      wait_clk(1700);
      chk(exp_q.size() == 0, "R7", "all stretched bytes delivered", exp_q.size(), 0);

      // R10: repeated start
      start_c();
      send_byte({OWN, 1'b0}, 1, a);
      send_byte(8'h11, 1, a);
      start_c();
      chk(addressed == 0, "R10", "repeated start clears addressed", addressed, 0);
      send_byte({OWN ^ 7'h10, 1'b0}, 0, a);
      chk(a == 1'b1, "R10", "new address frame decoded", a, 1);
      start_c();
      send_byte({OWN, 1'b0}, 1, a);
      chk(a == 1'b0, "R10", "match after second restart", a, 0);
      send_byte(8'h77, 1, a);
      stop_c();
      chk(addressed == 0, "R2", "stop after restart", addressed, 0);
      wait_clk(50);
      chk(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule